// File: doc/BRIEF.md
# Serial Trim DAC Loader

This block keeps sixteen on-board 8-bit trim converters programmed through a shared two-wire serial pair (clock and data) and a separate load strobe. A host presents a channel index with an 8-bit code on a valid/ready request port. When the code differs from the one last sent to that channel, the block shifts out a 12-bit frame and then pulses the load strobe, which makes the addressed converter latch the code. When the code is the same as the stored one, the request is accepted and nothing moves on the serial pins.

A shadow register file holds the last code for every channel. A combinational read port returns it. After reset, the block writes the mid-scale code 127 to every channel, one after another, before it accepts any host request. Two other devices share the serial pair: an EEPROM chip select and its write-protect release. Both stay inactive the whole time.

Back-pressure rules: a request is taken on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low during the power-on sweep and for as long as `busy` is high. A host that holds `req_valid` with stable fields simply waits. Each acceptance produces at most one frame.

Top module: `trimdac_loader`

## Requirements
- R1: Each frame carries 12 bits on 12 rising edges of `ser_clk`: first the 4-bit channel index, then the 8-bit code, each sent most significant bit first.
- R2: `ser_data` changes only while `ser_clk` is low. It is held stable for as long as `ser_clk` stays high, so the receiver samples on the rising edge.
- R3: After the twelfth bit, `load_strobe` goes high for HALF_CYC cycles and then low again. `ser_clk` is low whenever `load_strobe` is high.
- R4: `eeprom_cs` and `eeprom_wp_off` are low at all times, including during and after reset.
- R5: After reset the block sends 16 frames, one for each channel in ascending order 0..15, all with code 127. `req_ready` stays low until the last of these frames has finished. A reset in the middle of a frame aborts that frame and starts the sweep again.
- R6: An accepted request whose code equals the stored code for its channel produces no serial activity, and `busy` stays low.
- R7: `rd_value` always shows the stored code of the channel on `rd_chan`, combinationally. After reset every channel reads 127, and after each acceptance the channel reads the code that was accepted.
- R8: `busy` is low during reset. It goes high in the cycle after a frame starts and stays high for 4*HALF_CYC*... exactly 12*2*HALF_CYC + 2*HALF_CYC cycles (52 with the defaults), until the load strobe has been released. `req_ready` is low while `busy` is high.
- R9: An accepted request with a changed code starts its frame in the next cycle (`busy` rises). A request held valid during `busy` is accepted once, after the current frame, and frames leave in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_chan | input | 4 | Target channel of the request |
| req_value | input | 8 | Code for that channel |
| rd_chan | input | 4 | Channel selected for readback |
| rd_value | output | 8 | Stored code of `rd_chan` |
| busy | output | 1 | A frame or load pulse is in progress |
| ser_clk | output | 1 | Serial clock |
| ser_data | output | 1 | Serial data |
| load_strobe | output | 1 | Latch pulse for the addressed converter |
| eeprom_cs | output | 1 | EEPROM select, held inactive (low) |
| eeprom_wp_off | output | 1 | EEPROM write-protect release, held inactive (low) |

## Verification
The hardest case to reach from the ports is a request that arrives while a frame is still shifting: it has to wait through the whole frame and then be taken exactly once. The bench gets there by raising a second request on the very next cycle after an acceptance and holding it valid. It counts the busy cycles that pass before the second acceptance, and it decodes both frames from the pins. A reset applied partway through a frame is used to show that the power-on sweep restarts cleanly. Requests with repeated codes are mixed into the vector walk, so the silent path is exercised between real frames.

// File: rtl/trimdac_pkg.sv
package trimdac_pkg;
  typedef enum logic [2:0] {
    SH_IDLE,
    SH_LO,
    SH_HI,
    SH_LOAD,
    SH_REL
  } shift_state_e;
endpackage

// File: rtl/trimdac_shadow.sv
module trimdac_shadow #(
  parameter int NUM_CH   = 16,
  parameter int DATA_W   = 8,
  parameter int INIT_VAL = 127,
  localparam int CH_W    = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_chan,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CH_W-1:0]   rd_a_chan,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [CH_W-1:0]   rd_b_chan,
  output logic [DATA_W-1:0] rd_b_data
);
  logic [DATA_W-1:0] mem [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mem[g] <= DATA_W'(INIT_VAL);
      end else if (wr_en && (wr_chan == CH_W'(g))) begin
        mem[g] <= wr_data;
      end
    end
  end

  assign rd_a_data = mem[rd_a_chan];
  assign rd_b_data = mem[rd_b_chan];

  // R7
  shadow_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem[$past(wr_chan)] == $past(wr_data)));
endmodule

// File: rtl/trimdac_shifter.sv
module trimdac_shifter
  import trimdac_pkg::*;
#(
  parameter int FRAME_W  = 12,
  parameter int HALF_CYC = 2,
  localparam int BC_W    = $clog2(FRAME_W),
  localparam int TC_W    = $clog2(HALF_CYC) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  output logic               busy,
  output logic               sclk,
  output logic               sdata,
  output logic               load
);
  shift_state_e       state;
  logic [FRAME_W-1:0] shreg;
  logic [BC_W-1:0]    bits_left;
  logic [TC_W-1:0]    tcnt;
  logic               phase_end;

  assign phase_end = (tcnt == TC_W'(HALF_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SH_IDLE;
      shreg     <= '0;
      bits_left <= '0;
      tcnt      <= '0;
    end else begin
      if (state != SH_IDLE) begin
        tcnt <= phase_end ? '0 : tcnt + 1'b1;
      end
      case (state)
        SH_IDLE: if (start) begin
          shreg     <= frame;
          bits_left <= BC_W'(FRAME_W - 1);
          tcnt      <= '0;
          state     <= SH_LO;
        end
        SH_LO: if (phase_end) state <= SH_HI;
        SH_HI: if (phase_end) begin
          if (bits_left == '0) begin
            state <= SH_LOAD;
          end else begin
            shreg     <= {shreg[FRAME_W-2:0], 1'b0};
            bits_left <= bits_left - 1'b1;
            state     <= SH_LO;
          end
        end
        SH_LOAD: if (phase_end) state <= SH_REL;
        SH_REL:  if (phase_end) state <= SH_IDLE;
        default: state <= SH_IDLE;
      endcase
    end
  end

  assign busy  = (state != SH_IDLE);
  assign sclk  = (state == SH_HI);
  assign sdata = ((state == SH_LO) || (state == SH_HI)) ? shreg[FRAME_W-1] : 1'b0;
  assign load  = (state == SH_LOAD);

  // R2
  data_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdata));
  // R3
  strobe_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !sclk);
  // R8
  start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/trimdac_loader.sv
module trimdac_loader #(
  parameter int NUM_CH   = 16,
  parameter int DATA_W   = 8,
  parameter int HALF_CYC = 2,
  parameter int INIT_VAL = 127,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int FRAME_W = CH_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CH_W-1:0]   req_chan,
  input  logic [DATA_W-1:0] req_value,
  input  logic [CH_W-1:0]   rd_chan,
  output logic [DATA_W-1:0] rd_value,
  output logic              busy,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              load_strobe,
  output logic              eeprom_cs,
  output logic              eeprom_wp_off
);
  logic              sweep_active;
  logic [CH_W-1:0]   sweep_idx;
  logic              accept;
  logic              changed;
  logic [DATA_W-1:0] stored_req;
  logic              sh_start;
  logic [FRAME_W-1:0] sh_frame;
  logic              sh_busy;

  trimdac_shadow #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .INIT_VAL(INIT_VAL)) u_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (accept),
    .wr_chan   (req_chan),
    .wr_data   (req_value),
    .rd_a_chan (rd_chan),
    .rd_a_data (rd_value),
    .rd_b_chan (req_chan),
    .rd_b_data (stored_req)
  );

  assign req_ready = !sh_busy && !sweep_active;
  assign accept    = req_valid && req_ready;
  assign changed   = (stored_req != req_value);

  always_comb begin
    sh_start = 1'b0;
    sh_frame = '0;
    if (sweep_active && !sh_busy) begin
      sh_start = 1'b1;
      sh_frame = {sweep_idx, DATA_W'(INIT_VAL)};
    end else if (accept && changed) begin
      sh_start = 1'b1;
      sh_frame = {req_chan, req_value};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sweep_active <= 1'b1;
      sweep_idx    <= '0;
    end else if (sweep_active && !sh_busy) begin
      if (sweep_idx == CH_W'(NUM_CH - 1)) begin
        sweep_active <= 1'b0;
      end else begin
        sweep_idx <= sweep_idx + 1'b1;
      end
    end
  end

  trimdac_shifter #(.FRAME_W(FRAME_W), .HALF_CYC(HALF_CYC)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .start (sh_start),
    .frame (sh_frame),
    .busy  (sh_busy),
    .sclk  (ser_clk),
    .sdata (ser_data),
    .load  (load_strobe)
  );

  assign busy          = sh_busy;
  assign eeprom_cs     = 1'b0;
  assign eeprom_wp_off = 1'b0;

  // R6
  same_code_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !changed) |=> !busy);
  // R9
  new_code_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && changed) |=> busy);
  // R5
  sweep_tail_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sweep_active) |-> busy);
endmodule

// File: tb/sim_trimdac_loader.sv
module sim_trimdac_loader;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [3:0] req_chan = '0;
  logic [7:0] req_value = '0;
  logic [3:0] rd_chan = '0;
  logic [7:0] rd_value;
  logic       busy, ser_clk, ser_data, load_strobe, eeprom_cs, eeprom_wp_off;

  always #5 clk = ~clk;

  trimdac_loader u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_value(req_value), .rd_chan(rd_chan),
    .rd_value(rd_value), .busy(busy), .ser_clk(ser_clk), .ser_data(ser_data),
    .load_strobe(load_strobe), .eeprom_cs(eeprom_cs), .eeprom_wp_off(eeprom_wp_off)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pin monitor: decodes frames and counts protocol violations
  int         fr_n = 0;
  logic [3:0] fr_chan [64];
  logic [7:0] fr_val  [64];
  int         fr_bits [64];
  int         mon_bits = 0;
  logic [11:0] mon_sh = '0;
  logic       p_clk = 0, p_data = 0, p_load = 0;
  int         viol_r2 = 0, viol_r3 = 0, viol_r4 = 0;

  always @(negedge clk) begin
    if (eeprom_cs || eeprom_wp_off) viol_r4++;
    if (!rst_n) begin
      mon_bits = 0;
    end else begin
      if (ser_clk && !p_clk) begin
        mon_sh = {mon_sh[10:0], ser_data};
        mon_bits++;
      end
      if (ser_clk && p_clk && (ser_data != p_data)) viol_r2++;
      if (load_strobe && ser_clk) viol_r3++;
      if (load_strobe && !p_load) begin
        if (fr_n < 64) begin
          fr_chan[fr_n] = mon_sh[11:8];
          fr_val[fr_n]  = mon_sh[7:0];
          fr_bits[fr_n] = mon_bits;
        end
        fr_n++;
        mon_bits = 0;
      end
    end
    p_clk = ser_clk; p_data = ser_data; p_load = load_strobe;
  end

  int busycnt;

  task automatic send(input logic [3:0] ch, input logic [7:0] v);
    busycnt = 0;
    @(negedge clk);
    req_chan = ch; req_value = v; req_valid = 1'b1;
    while (!req_ready) begin
      if (busy) busycnt++;
      @(negedge clk);
    end
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    for (int i = 0; i < 2000 && (busy || !req_ready); i++) @(negedge clk);
  endtask

  task automatic check_sweep(input int base);
    for (int i = 0; i < 2000 && !req_ready; i++) @(negedge clk);
    chk(fr_n - base == 16, "R5 sweep frame count", fr_n - base, 16);
    for (int i = 0; i < 16; i++) begin
      chk(fr_chan[base+i] == 4'(i), "R5 sweep channel order", fr_chan[base+i], i);
      chk(fr_val[base+i] == 8'd127, "R5 sweep code", fr_val[base+i], 127);
      chk(fr_bits[base+i] == 12, "R1 bits per frame", fr_bits[base+i], 12);
    end
  endtask

  // {channel, code}
  localparam logic [11:0] VEC [10] = '{
    {4'd3, 8'hA5}, {4'd3, 8'hA5}, {4'd0, 8'h00}, {4'd15, 8'hFF}, {4'd15, 8'hFF},
    {4'd7, 8'd127}, {4'd8, 8'h5A}, {4'd1, 8'h80}, {4'd14, 8'h01}, {4'd0, 8'h00}
  };

  logic [7:0] model [16];

  initial begin
    repeat (4) @(negedge clk);
    chk(!busy && !ser_clk && !load_strobe, "R8 idle in reset", busy, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!req_ready, "R5 ready low in sweep", req_ready, 0);
    check_sweep(0);
    for (int c = 0; c < 16; c++) begin
      rd_chan = 4'(c); #1;
      chk(rd_value == 8'd127, "R7 readback after reset", rd_value, 127);
      model[c] = 8'd127;
    end

    foreach (VEC[k]) begin
      int base;
      bit ch;
      base = fr_n;
      ch = (model[VEC[k][11:8]] != VEC[k][7:0]);
      send(VEC[k][11:8], VEC[k][7:0]);
      @(negedge clk);
      if (!ch) chk(!busy, "R6 no busy on same code", busy, 0);
      else     chk(busy, "R9 busy after accept", busy, 1);
      wait_idle();
      chk(fr_n - base == (ch ? 1 : 0), ch ? "R9 one frame" : "R6 no frame", fr_n - base, ch ? 1 : 0);
      if (ch) begin
        chk(fr_chan[fr_n-1] == VEC[k][11:8], "R1 channel field", fr_chan[fr_n-1], VEC[k][11:8]);
        chk(fr_val[fr_n-1] == VEC[k][7:0], "R1 code field", fr_val[fr_n-1], VEC[k][7:0]);
      end
      model[VEC[k][11:8]] = VEC[k][7:0];
      rd_chan = VEC[k][11:8]; #1;
      chk(rd_value == VEC[k][7:0], "R7 readback after write", rd_value, VEC[k][7:0]);
    end

    // back-pressure: second request held valid during a frame
    begin
      int base;
      base = fr_n;
      send(4'd2, 8'h11);
      send(4'd2, 8'h22);
      chk(busycnt == 52, "R8 busy length / ready held low", busycnt, 52);
      wait_idle();
      chk(fr_n - base == 2, "R9 one frame per accept", fr_n - base, 2);
      chk(fr_val[base] == 8'h11 && fr_val[base+1] == 8'h22, "R9 frame order",
          fr_val[base+1], 8'h22);
    end

    // reset in the middle of a frame
    begin
      int base;
      send(4'd9, 8'h3C);
      repeat (10) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk); @(negedge clk);
      chk(!busy && !load_strobe && !ser_clk, "R8 abort on reset", busy, 0);
      rd_chan = 4'd9; #1;
      chk(rd_value == 8'd127, "R7 readback restored by reset", rd_value, 127);
      base = fr_n;
      @(posedge clk); #1 rst_n = 1'b1;
      check_sweep(base);
    end

    chk(viol_r2 == 0, "R2 data stable while clock high", viol_r2, 0);
    chk(viol_r3 == 0, "R3 strobe only with clock low", viol_r3, 0);
    chk(viol_r4 == 0, "R4 eeprom pins inactive", viol_r4, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule